// File: doc/BRIEF.md
# Flash End-Sector Protection Command Controller

This block is a clocked model of the command front end that guards the two end sectors of a sixteen-sector flash device. Bus writes carry an address and a data byte. A small sequencer turns runs of these writes into commands: lock a sector, unprotect a sector, enter identifier-read mode, or return to array reads. A protect flag is held for the bottom sector (sector 0) and one for the top sector (sector 15). These flags and a write-protect input decide whether a program or erase request from the rest of the chip may start.

A lock or unprotect finishes after a configurable number of clock cycles. The block then presents a status byte until the next valid command. A power-down input abandons all work in progress, clears the status byte and releases the read bus. Reads resume only after a recovery count that is set by a parameter.

Top module: `flash_guard_ctrl`

## Requirements
- R1: After reset both protect flags are clear, the read mode is array read (`rd_data` equals `arr_data`), `pe_busy` is low and `rd_drive` is high.
- R2: The six writes 0xAA@0x5555, 0x55@0x2AAA, 0x60@0x5555, 0xAA@0x5555, 0x55@0x2AAA and then 0x20 lock a sector, with write-protect high. The sector number is taken from the top four address bits of the sixth write. The flag is set when the operation ends. From then on, reads return the status byte with bit 7 (done) set.
- R3: The same first five writes followed by 0x40 clear the addressed sector's flag, with the same completion behaviour.
- R4: A write that breaks a sequence returns the sequencer to idle, so the rest of that sequence has no effect. A write of 0xF0 at any point selects array-read mode.
- R5: A lock or unprotect written while write-protect is low still completes (bit 7 set) but leaves both flags unchanged.
- R6: A lock or unprotect addressed to any sector other than 0 or 15 changes no flag.
- R7: After 0xAA@0x5555, 0x55@0x2AAA, 0x90@0x5555, reads at offset 0 return 0xC2, at offset 1 return 0xF1, and at offset 2 return {6'b0, top flag, bottom flag}. Any other offset returns 0. This holds until 0xF0 is written.
- R8: A program/erase request starts (`pe_busy` rises) when write-protect is high, or when the target sector is not protected. Otherwise it is refused, and status bit 4 is set and stays set.
- R9: Program/erase operations never change the protect flags.
- R10: While `wake` is low, `rd_drive` is low and bus writes and requests are ignored. A running program/erase or lock/unprotect is aborted with flags unchanged. The status byte is cleared and the read mode returns to array read.
- R11: After `wake` rises, `rd_drive` stays low for exactly REC_CYCLES clock edges, and writes stay ignored for that time.
- R12: Status-read mode persists across reads and across writes that do not form a valid command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wake | input | 1 | Low = power down |
| wp_hi | input | 1 | Write-protect level; high overrides protect flags |
| bus_wr | input | 1 | One-cycle bus write strobe |
| bus_addr | input | ADDR_W | Bus address |
| bus_wdata | input | 8 | Bus write data |
| arr_data | input | 8 | Array data shown in array-read mode |
| rd_data | output | 8 | Read data for the current mode and address |
| rd_drive | output | 1 | Read output enable (low = high impedance) |
| pe_req | input | 1 | Program/erase request pulse |
| pe_sector | input | 4 | Sector targeted by the request |
| pe_busy | output | 1 | Program/erase running |

## Verification
The bench locks and unprotects both end sectors with write-protect high and low, and confirms each result through the identifier read. A design that ignored the write-protect level would change flags on a low-level sequence. A sequence is broken just before its last write, which catches a sequencer that keeps partial progress. Requests to protected sectors check that refusal raises a sticky error instead of starting work. Power-down is dropped in the middle of both kinds of operation, and the recovery window is counted edge by edge, so an off-by-one counter or an abort that still writes a flag is reported.

// File: rtl/fgc_pkg.sv
// Package: shared types for the flash guard controller.
// Assumes: read modes and sequencer states are only used inside this block.
package fgc_pkg;
    typedef enum logic [1:0] {
        MODE_ARRAY  = 2'd0,
        MODE_IDENT  = 2'd1,
        MODE_STATUS = 2'd2
    } rd_mode_e;

    typedef enum logic [2:0] {
        SQ_IDLE, SQ_K1, SQ_K2, SQ_SETUP, SQ_S1, SQ_S2
    } seq_e;

    localparam logic [7:0] KEY_A    = 8'hAA;
    localparam logic [7:0] KEY_B    = 8'h55;
    localparam logic [7:0] CMD_SET  = 8'h60;
    localparam logic [7:0] CMD_LOCK = 8'h20;
    localparam logic [7:0] CMD_FREE = 8'h40;
    localparam logic [7:0] CMD_ID   = 8'h90;
    localparam logic [7:0] CMD_RST  = 8'hF0;
endpackage

// File: rtl/fgc_cmd_decode.sv
// Module: write-sequence decoder. Emits one-cycle command pulses on the
// write that completes a sequence. Assumes bus_wr is a single-cycle strobe
// and that en is low whenever writes must be ignored.
module fgc_cmd_decode #(
    parameter int ADDR_W = 20,
    parameter int KEY_W  = 16,
    parameter logic [KEY_W-1:0] KEY_ADDR1 = 16'h5555,
    parameter logic [KEY_W-1:0] KEY_ADDR2 = 16'h2AAA
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              halt,
    input  logic              en,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic              go_lock,
    output logic              go_free,
    output logic              go_id,
    output logic              go_rst
);
    import fgc_pkg::*;

    seq_e state_q, state_d;
    logic hit1, hit2, fire;

    assign hit1 = (addr[KEY_W-1:0] == KEY_ADDR1);
    assign hit2 = (addr[KEY_W-1:0] == KEY_ADDR2);
    assign fire = en && wr;

    // Next-state and command pulses for the current write.
    always_comb begin
        state_d = state_q;
        go_lock = 1'b0;
        go_free = 1'b0;
        go_id   = 1'b0;
        go_rst  = 1'b0;
        if (fire) begin
            state_d = SQ_IDLE;
            if (wdata == CMD_RST) begin
                go_rst = 1'b1;
            end else begin
                case (state_q)
                    SQ_IDLE:  if (hit1 && wdata == KEY_A) state_d = SQ_K1;
                    SQ_K1:    if (hit2 && wdata == KEY_B) state_d = SQ_K2;
                    SQ_K2: begin
                        if (hit1 && wdata == CMD_SET) state_d = SQ_SETUP;
                        go_id = hit1 && (wdata == CMD_ID);
                    end
                    SQ_SETUP: if (hit1 && wdata == KEY_A) state_d = SQ_S1;
                    SQ_S1:    if (hit2 && wdata == KEY_B) state_d = SQ_S2;
                    SQ_S2: begin
                        go_lock = (wdata == CMD_LOCK);
                        go_free = (wdata == CMD_FREE);
                    end
                    default:  state_d = SQ_IDLE;
                endcase
            end
        end
    end

    // Sequencer state register; power-down returns it to idle.
    always_ff @(posedge clk) begin
        if (!rst_n || halt) state_q <= SQ_IDLE;
        else                state_q <= state_d;
    end

    assert_halt_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        halt |=> (state_q == SQ_IDLE));
    assert_one_cmd_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({go_lock, go_free, go_id, go_rst}));
endmodule

// File: rtl/fgc_protect.sv
// Module: end-sector protect flags and the timed lock/unprotect operation.
// Assumes start pulses never arrive while busy (the top gates writes).
// Flag bit 0 is sector 0, bit 1 is the top sector.
module fgc_protect #(
    parameter int SECTORS   = 16,
    parameter int OP_CYCLES = 8,
    localparam int SEC_W = $clog2(SECTORS),
    localparam int CNT_W = $clog2(OP_CYCLES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             halt,
    input  logic             go_lock,
    input  logic             go_free,
    input  logic [SEC_W-1:0] sector,
    input  logic             wp_hi,
    output logic [1:0]       prot,
    output logic             busy,
    output logic             done
);
    logic [CNT_W-1:0] cnt_q;
    logic [1:0]       mask_q;
    logic             set_q;

    // Operation timer, pending mask and flag update at completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prot <= 2'b00; busy <= 1'b0; done <= 1'b0;
            cnt_q <= '0; mask_q <= 2'b00; set_q <= 1'b0;
        end else if (halt) begin
            busy <= 1'b0; done <= 1'b0; cnt_q <= '0;
        end else if (go_lock || go_free) begin
            busy   <= 1'b1;
            done   <= 1'b0;
            cnt_q  <= CNT_W'(OP_CYCLES);
            set_q  <= go_lock;
            mask_q <= wp_hi ? {sector == SEC_W'(SECTORS - 1), sector == '0} : 2'b00;
        end else if (busy) begin
            cnt_q <= cnt_q - 1'b1;
            if (cnt_q == CNT_W'(1)) begin
                busy <= 1'b0;
                done <= 1'b1;
                prot <= set_q ? (prot | mask_q) : (prot & ~mask_q);
            end
        end
    end

    assert_flag_change_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(prot) |-> $past(busy) && !$past(halt));
    assert_done_after_op_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(busy));
endmodule

// File: rtl/fgc_pe_gate.sv
// Module: program/erase admission and run timer. Decides from the
// write-protect level and protect flags whether a request may start;
// a refused request sets a sticky error. Assumes pe_req is one cycle.
module fgc_pe_gate #(
    parameter int SECTORS   = 16,
    parameter int PE_CYCLES = 6,
    localparam int SEC_W = $clog2(SECTORS),
    localparam int CNT_W = $clog2(PE_CYCLES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             halt,
    input  logic             en,
    input  logic             pe_req,
    input  logic [SEC_W-1:0] pe_sector,
    input  logic             wp_hi,
    input  logic [1:0]       prot,
    output logic             pe_busy,
    output logic             err
);
    logic [CNT_W-1:0] cnt_q;
    logic             guarded, allow, take;

    assign guarded = (pe_sector == '0 && prot[0]) ||
                     (pe_sector == SEC_W'(SECTORS - 1) && prot[1]);
    assign allow   = wp_hi || !guarded;
    assign take    = en && pe_req && !pe_busy;

    // Run timer and sticky refusal flag.
    always_ff @(posedge clk) begin
        if (!rst_n || halt) begin
            pe_busy <= 1'b0; cnt_q <= '0; err <= 1'b0;
        end else if (take && allow) begin
            pe_busy <= 1'b1; cnt_q <= CNT_W'(PE_CYCLES);
        end else begin
            if (take) err <= 1'b1;
            if (pe_busy) begin
                cnt_q <= cnt_q - 1'b1;
                if (cnt_q == CNT_W'(1)) pe_busy <= 1'b0;
            end
        end
    end

    assert_block_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !wp_hi && pe_sector == '0 && prot[0] && !halt) |=> (!pe_busy && err));
endmodule

// File: rtl/flash_guard_ctrl.sv
// Module: top of the flash guard controller. Holds the read mode, the
// power-down recovery counter and the read multiplexer; ties the decoder,
// protect flags and program/erase gate together. Assumes all inputs are
// synchronous to clk and that array data is supplied from outside.
module flash_guard_ctrl #(
    parameter int ADDR_W     = 20,
    parameter int SECTORS    = 16,
    parameter int OP_CYCLES  = 8,
    parameter int PE_CYCLES  = 6,
    parameter int REC_CYCLES = 140,
    parameter logic [7:0] MAKER_ID = 8'hC2,
    parameter logic [7:0] PART_ID  = 8'hF1,
    localparam int SEC_W = $clog2(SECTORS),
    localparam int REC_W = $clog2(REC_CYCLES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wake,
    input  logic              wp_hi,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    input  logic [7:0]        arr_data,
    output logic [7:0]        rd_data,
    output logic              rd_drive,
    input  logic              pe_req,
    input  logic [SEC_W-1:0]  pe_sector,
    output logic              pe_busy
);
    import fgc_pkg::*;

    rd_mode_e         mode_q;
    logic [REC_W-1:0] rec_q;
    logic             halt, ready;
    logic             go_lock, go_free, go_id, go_rst;
    logic [1:0]       prot;
    logic             op_busy, op_done, pe_err;
    logic [7:0]       status;

    assign halt   = !wake;
    assign ready  = wake && (rec_q == '0);
    assign status = {op_done, 2'b00, pe_err, 4'b0000};

    fgc_cmd_decode #(.ADDR_W(ADDR_W)) u_dec (
        .clk(clk), .rst_n(rst_n), .halt(halt), .en(ready && !op_busy),
        .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
        .go_lock(go_lock), .go_free(go_free), .go_id(go_id), .go_rst(go_rst)
    );

    fgc_protect #(.SECTORS(SECTORS), .OP_CYCLES(OP_CYCLES)) u_prot (
        .clk(clk), .rst_n(rst_n), .halt(halt),
        .go_lock(go_lock), .go_free(go_free),
        .sector(bus_addr[ADDR_W-1 -: SEC_W]), .wp_hi(wp_hi),
        .prot(prot), .busy(op_busy), .done(op_done)
    );

    fgc_pe_gate #(.SECTORS(SECTORS), .PE_CYCLES(PE_CYCLES)) u_gate (
        .clk(clk), .rst_n(rst_n), .halt(halt), .en(ready),
        .pe_req(pe_req), .pe_sector(pe_sector), .wp_hi(wp_hi), .prot(prot),
        .pe_busy(pe_busy), .err(pe_err)
    );

    // Read mode follows completed commands; power-down forces array read.
    always_ff @(posedge clk) begin
        if (!rst_n || halt)         mode_q <= MODE_ARRAY;
        else if (go_rst)            mode_q <= MODE_ARRAY;
        else if (go_id)             mode_q <= MODE_IDENT;
        else if (go_lock || go_free) mode_q <= MODE_STATUS;
    end

    // Recovery counter: loaded while asleep, counts down after wake.
    always_ff @(posedge clk) begin
        if (!rst_n)              rec_q <= '0;
        else if (halt)           rec_q <= REC_W'(REC_CYCLES);
        else if (rec_q != '0)    rec_q <= rec_q - 1'b1;
    end

    // Read multiplexer for the current mode.
    always_comb begin
        rd_data = 8'h00;
        if (ready) begin
            case (mode_q)
                MODE_IDENT: begin
                    case (bus_addr[7:0])
                        8'h00:   rd_data = MAKER_ID;
                        8'h01:   rd_data = PART_ID;
                        8'h02:   rd_data = {6'b0, prot};
                        default: rd_data = 8'h00;
                    endcase
                end
                MODE_STATUS: rd_data = status;
                default:     rd_data = arr_data;
            endcase
        end
    end
    assign rd_drive = ready;

    assert_hiz_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !wake |-> !rd_drive);
    assert_status_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !wake |=> (status == 8'h00 && !pe_busy));
    assert_wake_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wake) |-> !rd_drive);
endmodule

// File: tb/flash_guard_ctrl_tb.sv
`timescale 1ns/1ps
module flash_guard_ctrl_tb;
    localparam int REC = 140;

    logic clk = 1'b0, rst_n = 1'b0, wake = 1'b1, wp_hi = 1'b1;
    logic bus_wr = 1'b0, pe_req = 1'b0;
    logic [19:0] bus_addr = '0;
    logic [7:0]  bus_wdata = '0, arr_data = 8'h3C, rd_data;
    logic [3:0]  pe_sector = '0;
    logic        rd_drive, pe_busy;
    int n_chk = 0, n_bad = 0;

    always #2.5 clk = ~clk;

    flash_guard_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .wake(wake), .wp_hi(wp_hi),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .arr_data(arr_data), .rd_data(rd_data), .rd_drive(rd_drive),
        .pe_req(pe_req), .pe_sector(pe_sector), .pe_busy(pe_busy)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [19:0] a, input logic [7:0] d);
        @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic head5();
        wr(20'h05555, 8'hAA); wr(20'h02AAA, 8'h55); wr(20'h05555, 8'h60);
        wr(20'h05555, 8'hAA); wr(20'h02AAA, 8'h55);
    endtask

    // Sector op then wait for done (status bit 7).
    task automatic sect_op(input logic [3:0] sec, input logic [7:0] cmd);
        head5();
        wr({sec, 16'h0000}, cmd);
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (rd_data[7]) break;
        end
    endtask

    task automatic read_at(input logic [19:0] a, output logic [7:0] d);
        @(negedge clk); bus_addr = a; #1 d = rd_data;
    endtask

    task automatic flags(input string req, input logic [7:0] exp);
        logic [7:0] d;
        wr(20'h05555, 8'hAA); wr(20'h02AAA, 8'h55); wr(20'h05555, 8'h90);
        read_at(20'h00002, d); check(req, d, exp);
        wr(20'h00000, 8'hF0);
    endtask

    task automatic pe(input logic [3:0] sec, input string req, input logic exp_busy);
        @(negedge clk); pe_sector = sec; pe_req = 1'b1;
        @(negedge clk); pe_req = 1'b0;
        check(req, {7'b0, pe_busy}, {7'b0, exp_busy});
        while (pe_busy) @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1 drive", {7'b0, rd_drive}, 8'h01);
        check("R1 array", rd_data, 8'h3C);
        check("R1 pe_busy", {7'b0, pe_busy}, 8'h00);
        flags("R1 flags", 8'h00);
    endtask

    task automatic t_lock();
        logic [7:0] d;
        wp_hi = 1'b1;
        sect_op(4'h0, 8'h20);
        check("R2 status", rd_data, 8'h80);
        read_at(20'h00123, d); check("R12 status read", d, 8'h80);
        wr(20'h01234, 8'h12);
        read_at(20'h00000, d); check("R12 stray write", d, 8'h80);
        flags("R2 bottom", 8'h01);
        sect_op(4'hF, 8'h20);
        flags("R2 top", 8'h03);
    endtask

    task automatic t_ident();
        logic [7:0] d;
        wr(20'h05555, 8'hAA); wr(20'h02AAA, 8'h55); wr(20'h05555, 8'h90);
        read_at(20'h00000, d); check("R7 maker", d, 8'hC2);
        read_at(20'h00001, d); check("R7 part", d, 8'hF1);
        read_at(20'h00003, d); check("R7 other", d, 8'h00);
        read_at(20'h00000, d); check("R7 held", d, 8'hC2);
        wr(20'h00000, 8'hF0);
        read_at(20'h00000, d); check("R4 reset cmd", d, 8'h3C);
    endtask

    task automatic t_wp_low();
        wp_hi = 1'b0;
        sect_op(4'h0, 8'h40);
        check("R5 done", rd_data, 8'h80);
        flags("R5 flags", 8'h03);
        wp_hi = 1'b1;
        sect_op(4'h5, 8'h40);
        flags("R6 other sector", 8'h03);
    endtask

    task automatic t_gate();
        wp_hi = 1'b0;
        pe(4'h0, "R8 blocked bottom", 1'b0);
        pe(4'hF, "R8 blocked top", 1'b0);
        pe(4'h7, "R8 open sector", 1'b1);
        sect_op(4'h5, 8'h20);
        check("R8 sticky err", rd_data, 8'h90);
        wr(20'h00000, 8'hF0);
        wp_hi = 1'b1;
        pe(4'h0, "R8 wp override", 1'b1);
        flags("R9 flags kept", 8'h03);
    endtask

    task automatic t_unprot_break();
        logic [7:0] d;
        sect_op(4'hF, 8'h40);
        flags("R3 top cleared", 8'h01);
        wr(20'h05555, 8'hAA); wr(20'h02AAA, 8'h55); wr(20'h05555, 8'h60);
        wr(20'h05555, 8'hAA); wr(20'h05555, 8'h77);
        wr(20'h02AAA, 8'h55); wr(20'h00000, 8'h40);
        repeat (12) @(negedge clk);
        read_at(20'h00000, d); check("R4 broken mode", d, 8'h3C);
        flags("R4 broken flags", 8'h01);
    endtask

    task automatic t_power();
        logic [7:0] d;
        wp_hi = 1'b1;
        pe(4'h0, "R10 pe start", 1'b1);
        @(negedge clk);
        @(negedge clk); pe_sector = 4'h3; pe_req = 1'b1;
        @(negedge clk); pe_req = 1'b0;
        wake = 1'b0; #1;
        check("R10 hiz", {7'b0, rd_drive}, 8'h00);
        @(negedge clk);
        check("R10 pe abort", {7'b0, pe_busy}, 8'h00);
        wake = 1'b1;
        repeat (REC - 1) @(posedge clk);
        #1 check("R11 still off", {7'b0, rd_drive}, 8'h00);
        @(posedge clk); #1 check("R11 ready", {7'b0, rd_drive}, 8'h01);
        head5(); wr(20'h00000, 8'h40);
        repeat (3) @(negedge clk);
        wake = 1'b0;
        @(negedge clk); wake = 1'b1;
        repeat (REC + 2) @(negedge clk);
        read_at(20'h00000, d); check("R10 array after", d, 8'h3C);
        flags("R10 op aborted", 8'h01);
        sect_op(4'h5, 8'h20);
        check("R10 status cleared", rd_data, 8'h80);
    endtask

    initial begin
        #(200000 * 5);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_lock();
        t_ident();
        t_wp_low();
        t_gate();
        t_unprot_break();
        t_power();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule